// File: doc/BRIEF.md
# Transmit Voice Activity Detector

This block decides whether speech is present on an 8-bit µ-law sample stream travelling in the transmit direction toward an echo canceller. A strobe marks each new sample at the 8 kHz frame rate. Every sample is turned into a linear magnitude with its sign discarded. The magnitude feeds a leaky average that tracks short-term signal level, and that level is compared against one of four thresholds spaced 6 dB apart.

The raw comparison does not drive the output directly. Speech is only declared after the level has stayed above threshold for two full 64-sample frames in a row. Silence is only declared after a hangover of 1600 samples (200 ms) with no sample above threshold. The decision appears on a voice output and on a separate status output. The two always carry the same value, and 1 means speech. A function enable clears and holds everything while it is low.

Top module: `voice_activity_detect`

## Requirements
- R1: Each sample byte is complemented. Bits [6:4] of the result are the exponent e and bits [3:0] are the mantissa m. The magnitude is ((2m+33)<<e)-33, in the range 0 to 8031. Bit 7 (the sign) has no effect on it.
- R2: On each accepted sample the accumulator A is updated as A <= A - (A>>5) + magnitude. The level is A>>5.
- R3: The threshold is 64<<thr_sel, giving 64, 128, 256 or 512. A sample counts as above only when the level after its update is strictly greater than the threshold.
- R4: While silent, voice_out rises on the 128th consecutive above sample (two 64-sample frames). Any sample that is not above restarts that count.
- R5: While speaking, voice_out falls on the 1600th consecutive sample that is not above. Any above sample restarts that count.
- R6: voice_status always equals voice_out.
- R7: While enable is 0, both outputs are 0 from the next clock edge. The accumulator and all counters are cleared, and strobed samples are ignored.
- R8: A sample strobed at clock edge N affects the outputs at edge N+3 and not before.
- R9: After reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Function enable; 0 clears and holds the detector |
| sample_valid | input | 1 | One-cycle strobe marking a new sample |
| sample_in | input | 8 | µ-law sample byte |
| thr_sel | input | 2 | Threshold choice, threshold = 64<<thr_sel |
| voice_out | output | 1 | 1 = speech present, 0 = silence |
| voice_status | output | 1 | Copy of the decision for a status register |

## Verification
Full-scale bursts that alternate the two sign values are run under every threshold setting. They show that the sign is ignored and that the onset and hangover counts are exact. A steady mid-level tone with magnitude 163 separates the settings that must detect it from those that must not. A sweep over all 256 codes compares expansion and averaging against an arithmetic model. Threshold changes made for a single sample break a run one sample short of onset or of hangover, which checks that both counters restart. Loud samples sent while the block is disabled must leave it silent, and after re-enable it must need a full new onset.

// File: rtl/vad_pkg.sv
// Shared constants for the voice activity detector.
// Assumes 8-bit mu-law input and a 13-bit maximum magnitude stored in MAG_W bits.
package vad_pkg;
    localparam int MAG_W      = 14;           // linear magnitude width
    localparam int AVG_SHIFT  = 5;            // leak coefficient 1/32
    localparam int ACC_W      = MAG_W + AVG_SHIFT;
    localparam int MAG_MAX    = 8031;         // largest expanded magnitude
    localparam int THR_BASE   = 64;           // lowest threshold, doubled per step
    localparam int FRAME_LEN  = 64;           // samples per frame
    localparam int ONSET_FRM  = 2;            // frames above threshold to declare speech
    localparam int HANG_LEN   = 1600;         // quiet samples to declare silence
endpackage

// File: rtl/vad_mulaw_mag.sv
// Expands a mu-law byte to its linear magnitude, dropping the sign, and
// registers it with a valid flag. Assumes at most one strobe per cycle.
module vad_mulaw_mag
    import vad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             in_valid,
    input  logic [7:0]       in_code,
    output logic             mag_valid,
    output logic [MAG_W-1:0] mag
);
    logic [7:0]       inv;
    logic [2:0]       expo;
    logic [3:0]       mant;
    logic [MAG_W-1:0] base;
    logic [MAG_W-1:0] mag_c;

    // Decode exponent and mantissa and form the biased magnitude.
    always_comb begin
        inv   = ~in_code;
        expo  = inv[6:4];
        mant  = inv[3:0];
        base  = MAG_W'({mant, 1'b0}) + MAG_W'(33);
        mag_c = (base << expo) - MAG_W'(33);
    end

    // Register the magnitude; disable drops samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            mag_valid <= 1'b0;
            mag       <= '0;
        end else begin
            mag_valid <= in_valid;
            if (in_valid) mag <= mag_c;
        end
    end

    AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mag_valid |-> (mag <= MAG_W'(MAG_MAX))); // R1
endmodule

// File: rtl/vad_energy.sv
// Leaky average of magnitude (coefficient 1/32) and threshold compare.
// Assumes thr_sel is stable around the sample being compared.
module vad_energy
    import vad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mag_valid,
    input  logic [MAG_W-1:0] mag,
    input  logic [1:0]       thr_sel,
    output logic             cmp_valid,
    output logic             above
);
    localparam logic [ACC_W-1:0] ACC_MAX =
        ACC_W'((MAG_MAX << AVG_SHIFT) + (1 << AVG_SHIFT) - 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;
    logic [ACC_W-1:0] thr;

    // Next accumulator value and the selected threshold.
    always_comb begin
        acc_nx = acc_q - (acc_q >> AVG_SHIFT) + ACC_W'(mag);
        thr    = ACC_W'(THR_BASE) << thr_sel;
    end

    // Update the average and register the compare result per sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc_q     <= '0;
            cmp_valid <= 1'b0;
            above     <= 1'b0;
        end else begin
            cmp_valid <= mag_valid;
            if (mag_valid) begin
                acc_q <= acc_nx;
                above <= (acc_nx >> AVG_SHIFT) > thr;
            end
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= ACC_MAX); // R2
    AST_AVG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(mag_valid)) |-> $stable(acc_q)); // R2
endmodule

// File: rtl/vad_hold_fsm.sv
// Onset and hangover timing. Speech is declared after ONSET_FRM whole frames
// of consecutive above samples; silence after HANG_LEN consecutive quiet ones.
module vad_hold_fsm
    import vad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmp_valid,
    input  logic above,
    output logic voice
);
    localparam int FRM_W  = $clog2(FRAME_LEN);
    localparam int NFRM_W = $clog2(ONSET_FRM + 1);
    localparam int HANG_W = $clog2(HANG_LEN + 1);

    logic              voice_q;
    logic [FRM_W-1:0]  smp_ctr;
    logic [NFRM_W-1:0] frm_ctr;
    logic [HANG_W-1:0] hang_ctr;

    // Count above runs while silent and quiet runs while speaking.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            voice_q  <= 1'b0;
            smp_ctr  <= '0;
            frm_ctr  <= '0;
            hang_ctr <= '0;
        end else if (cmp_valid) begin
            if (!voice_q) begin
                hang_ctr <= '0;
                if (!above) begin
                    smp_ctr <= '0;
                    frm_ctr <= '0;
                end else if (smp_ctr == FRM_W'(FRAME_LEN - 1)) begin
                    smp_ctr <= '0;
                    if (frm_ctr == NFRM_W'(ONSET_FRM - 1)) begin
                        frm_ctr <= '0;
                        voice_q <= 1'b1;
                    end else begin
                        frm_ctr <= frm_ctr + 1'b1;
                    end
                end else begin
                    smp_ctr <= smp_ctr + 1'b1;
                end
            end else begin
                smp_ctr <= '0;
                frm_ctr <= '0;
                if (above) begin
                    hang_ctr <= '0;
                end else if (hang_ctr == HANG_W'(HANG_LEN - 1)) begin
                    hang_ctr <= '0;
                    voice_q  <= 1'b0;
                end else begin
                    hang_ctr <= hang_ctr + 1'b1;
                end
            end
        end
    end

    assign voice = voice_q;

    AST_ONSET_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(voice_q) |-> $past(cmp_valid && above)); // R4
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(voice_q) && $past(en)) |-> $past(cmp_valid && !above)); // R5
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !voice_q); // R7
    AST_HANG_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !voice_q |-> (hang_ctr == '0)); // R5
endmodule

// File: rtl/voice_activity_detect.sv
// Top of the transmit voice activity detector: expansion, averaging and
// hold timing in a three-stage pipeline. Assumes samples at least 3 cycles apart.
module voice_activity_detect
    import vad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sample_valid,
    input  logic [7:0] sample_in,
    input  logic [1:0] thr_sel,
    output logic       voice_out,
    output logic       voice_status
);
    logic             mag_valid;
    logic [MAG_W-1:0] mag;
    logic             cmp_valid;
    logic             above;
    logic             voice;

    vad_mulaw_mag u_mag (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .in_valid  (sample_valid),
        .in_code   (sample_in),
        .mag_valid (mag_valid),
        .mag       (mag)
    );

    vad_energy u_energy (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .mag_valid (mag_valid),
        .mag       (mag),
        .thr_sel   (thr_sel),
        .cmp_valid (cmp_valid),
        .above     (above)
    );

    vad_hold_fsm u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .cmp_valid (cmp_valid),
        .above     (above),
        .voice     (voice)
    );

    assign voice_out    = voice;
    assign voice_status = voice;

    AST_NO_SPONTANEOUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(voice_out) |-> $past(sample_valid, 3)); // R8
endmodule

// File: tb/voice_activity_detect_tb_top.sv
// Self-checking bench: arithmetic model of expansion, averaging and hold timing.
module voice_activity_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       sample_valid = 1'b0;
    logic [7:0] sample_in = 8'hFF;
    logic [1:0] thr_sel = 2'd0;
    logic       voice_out;
    logic       voice_status;

    int checks = 0;
    int fails  = 0;

    // Model state
    int m_acc = 0, m_run = 0, m_hang = 0;
    bit m_voice = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    voice_activity_detect dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample_valid(sample_valid),
        .sample_in(sample_in), .thr_sel(thr_sel),
        .voice_out(voice_out), .voice_status(voice_status)
    );

    task automatic check(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    function automatic int expand(input int s);
        int c, e, m, p;
        c = 255 - s;
        e = (c / 16) % 8;
        m = c % 16;
        p = 1;
        for (int i = 0; i < e; i++) p = p * 2;
        return (2 * m + 33) * p - 33;
    endfunction

    task automatic model_step(input int s);
        bit hot;
        m_acc = m_acc - m_acc / 32 + expand(s);
        hot = (m_acc / 32) > (64 << thr_sel);
        if (!m_voice) begin
            m_hang = 0;
            if (hot) begin
                m_run++;
                if (m_run == 128) begin m_voice = 1'b1; m_run = 0; end
            end else m_run = 0;
        end else begin
            m_run = 0;
            if (hot) m_hang = 0;
            else begin
                m_hang++;
                if (m_hang == 1600) begin m_voice = 1'b0; m_hang = 0; end
            end
        end
    endtask

    // One sample: strobe, check unchanged after two edges, then the new value.
    task automatic send(input int s, input string tag);
        @(negedge clk);
        sample_in = 8'(s);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        @(negedge clk);
        check(voice_out, m_voice, "R8 output early");
        if (enable) model_step(s);
        @(negedge clk);
        check(voice_out, m_voice, tag);
        check(voice_status, voice_out, "R6 status mirror");
    endtask

    task automatic set_enable(input bit v);
        @(negedge clk);
        enable = v;
        if (!v) begin m_acc = 0; m_run = 0; m_hang = 0; m_voice = 1'b0; end
        @(negedge clk);
        if (!v) check(voice_out, 1'b0, "R7 disable clears");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        check(voice_out, 1'b0, "R9 reset voice");
        check(voice_status, 1'b0, "R9 reset status");
        rst_n = 1'b1;
        set_enable(1'b1);

        // Full-scale bursts of both signs and a mid tone (magnitude 163) per threshold.
        for (int sel = 0; sel < 4; sel++) begin
            thr_sel = 2'(sel);
            for (int i = 0; i < 300; i++) send((i % 2) ? 8'h00 : 8'h80, "R4 R1 burst onset");
            check(voice_out, 1'b1, "R4 burst detected");
            for (int i = 0; i < 1900; i++) send(8'hFF, "R5 hangover");
            check(voice_out, 1'b0, "R5 silence after hangover");
            for (int i = 0; i < 400; i++) send(8'hD7, "R3 mid tone");
            check(voice_out, (sel < 2), "R3 mid tone threshold");
            for (int i = 0; i < 1900; i++) send(8'hFF, "R5 hangover");
        end

        // Onset run broken one sample short by a raised threshold.
        thr_sel = 2'd2;
        for (int i = 0; i < 300; i++) send(8'hD7, "R3 settle below");
        thr_sel = 2'd1;
        for (int i = 0; i < 127; i++) send(8'hD7, "R4 run");
        check(voice_out, 1'b0, "R4 127 not enough");
        thr_sel = 2'd3;
        send(8'hD7, "R4 run break");
        thr_sel = 2'd1;
        for (int i = 0; i < 127; i++) send(8'hD7, "R4 restart");
        check(voice_out, 1'b0, "R4 restarted count");
        send(8'hD7, "R4 128th sample");
        check(voice_out, 1'b1, "R4 onset at 128");

        // Hangover broken one sample short by a lowered threshold.
        thr_sel = 2'd2;
        for (int i = 0; i < 1599; i++) send(8'hD7, "R5 hang");
        check(voice_out, 1'b1, "R5 1599 not enough");
        thr_sel = 2'd1;
        send(8'hD7, "R5 hang break");
        thr_sel = 2'd2;
        for (int i = 0; i < 1599; i++) send(8'hD7, "R5 restart");
        check(voice_out, 1'b1, "R5 restarted count");
        send(8'hD7, "R5 1600th sample");
        check(voice_out, 1'b0, "R5 release at 1600");

        // Sweep all codes several times.
        thr_sel = 2'd1;
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 256; s++) send(s, "R1 R2 code sweep");

        // Disable while speaking, loud samples ignored, full onset after re-enable.
        thr_sel = 2'd0;
        for (int i = 0; i < 200; i++) send(8'h80, "R4 pre-disable");
        set_enable(1'b0);
        for (int i = 0; i < 200; i++) send(8'h80, "R7 ignored while disabled");
        set_enable(1'b1);
        for (int i = 0; i < 127; i++) send(8'h80, "R7 fresh onset");
        check(voice_out, 1'b0, "R7 state cleared");
        send(8'h80, "R7 onset after enable");
        check(voice_out, 1'b1, "R7 onset after enable");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule